// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the memory traffic that takes a processor core into an interrupt handler and back out of it. It owns the FLAGS, CS, IP and SP registers. When it is handed an 8-bit interrupt type, it saves FLAGS, CS and IP on the stack and clears the trace and interrupt-enable flags. It then reads the handler's IP and CS from the vector entry that belongs to that type. When it is asked to return, it pulls IP, CS and FLAGS back off the stack. The stack segment comes in from outside. Deciding which interrupt to take, fetching instructions and doing arithmetic all happen elsewhere.

All traffic goes through one 16-bit word port with a 20-bit byte address. A physical stack address is the stack segment times 16 plus SP, and only the low 20 bits are kept. Each vector entry is four bytes wide: the IP word sits at type×4 and the CS word at type×4+2. The instruction unit can write the four registers through a load port, but only while the sequencer is idle. A one-cycle done pulse tells it to restart fetching at the new CS:IP.

Top module: `intr_seq`

## Requirements
- R1: After reset, ctx_flags=0002h, ctx_cs=FFFFh, ctx_ip=0000h and ctx_sp=0000h. mem_rd, mem_wr, busy and done are all 0.
- R2: An interrupt request, taken while idle, issues three writes in this order: FLAGS to stk_seg×16+(SP−2), then CS to stk_seg×16+(SP−4), then IP to stk_seg×16+(SP−6). Each accepted write lowers SP by 2.
- R3: The FLAGS word that gets written is the value from before the request. Once that write is accepted, flag bits 8 (trace) and 9 (interrupt enable) read 0 and every other bit keeps its value.
- R4: After the pushes, the block reads address type×4 into IP and then type×4+2 into CS. These reads lie inside 00000h–003FFh and leave SP unchanged.
- R5: A return request, taken while idle, reads IP from stk_seg×16+SP, then CS from stk_seg×16+SP+2, then FLAGS from stk_seg×16+SP+4. Each accepted read raises SP by 2.
- R6: An access with mem_ready low holds mem_addr, mem_rd, mem_wr and mem_wdata unchanged into the next cycle. The sequence only advances on a cycle where mem_ready is high.
- R7: done is high for exactly one cycle. That cycle follows the one in which the last access was accepted. The new register values are visible in it, and busy is already 0.
- R8: While busy is 1, req_int, req_iret and ld_en are ignored. If req_int and req_iret arrive together while idle, the interrupt is taken.
- R9: Stack address arithmetic wraps: SP wraps at 16 bits and the physical address wraps at 20 bits.
- R10: While idle, ld_en with no request in the same cycle loads all four registers on the next edge. If a request arrives in that same cycle, the load is ignored.
- R11: mem_rd and mem_wr are never high together, and neither is high while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_int | input | 1 | Start interrupt entry (single-cycle) |
| int_type | input | 8 | Interrupt type, sampled together with req_int |
| req_iret | input | 1 | Start interrupt return (single-cycle) |
| stk_seg | input | 16 | Stack segment value |
| ld_en | input | 1 | Load the four context registers |
| ld_flags | input | 16 | FLAGS value to load |
| ld_cs | input | 16 | CS value to load |
| ld_ip | input | 16 | IP value to load |
| ld_sp | input | 16 | SP value to load |
| mem_addr | output | 20 | Byte address of the current word access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Completes the current access |
| ctx_flags | output | 16 | FLAGS register |
| ctx_cs | output | 16 | CS register |
| ctx_ip | output | 16 | IP register |
| ctx_sp | output | 16 | SP register |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches several properties on every cycle. It confirms that a stalled access holds steady. It confirms that SP moves by exactly two on every accepted push or pop. It confirms that the trace and interrupt-enable bits are cleared right after FLAGS is saved, that vector reads stay inside the table, and that done is a single-cycle pulse that arrives only when the block is idle. Some properties need the bench's reference model instead. That model checks the exact order and addresses of the five entry accesses and three return accesses, and the values restored into the registers. It also covers address wrap with a high stack segment, requests and loads that arrive mid-sequence and must be dropped, and the arbitration when both requests arrive together.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_PUSH_F  = 4'd1,
    ST_PUSH_CS = 4'd2,
    ST_PUSH_IP = 4'd3,
    ST_VEC_IP  = 4'd4,
    ST_VEC_CS  = 4'd5,
    ST_POP_IP  = 4'd6,
    ST_POP_CS  = 4'd7,
    ST_POP_F   = 4'd8
  } seq_state_e;

  function automatic logic is_return(seq_state_e s);
    return (s == ST_POP_IP) || (s == ST_POP_CS) || (s == ST_POP_F);
  endfunction

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_int,
  input  logic          req_iret,
  input  logic [TW-1:0] int_type,
  input  logic          mem_ready,
  output seq_state_e    state,
  output logic [TW-1:0] vtype,
  output logic          busy,
  output logic          done
);

  seq_state_e state_nxt;
  logic       done_nxt;
  logic       vtype_en;

  always_comb begin
    state_nxt = state;
    done_nxt  = 1'b0;
    vtype_en  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_int) begin
          state_nxt = ST_PUSH_F;
          vtype_en  = 1'b1;
        end else if (req_iret) begin
          state_nxt = ST_POP_IP;
        end
      end
      ST_PUSH_F:  if (mem_ready) state_nxt = ST_PUSH_CS;
      ST_PUSH_CS: if (mem_ready) state_nxt = ST_PUSH_IP;
      ST_PUSH_IP: if (mem_ready) state_nxt = ST_VEC_IP;
      ST_VEC_IP:  if (mem_ready) state_nxt = ST_VEC_CS;
      ST_VEC_CS: begin
        if (mem_ready) begin
          state_nxt = ST_IDLE;
          done_nxt  = 1'b1;
        end
      end
      ST_POP_IP:  if (mem_ready) state_nxt = ST_POP_CS;
      ST_POP_CS:  if (mem_ready) state_nxt = ST_POP_F;
      ST_POP_F: begin
        if (mem_ready) begin
          state_nxt = ST_IDLE;
          done_nxt  = 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtype <= '0;
    end else if (vtype_en) begin
      vtype <= int_type;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/intr_seq_regs.sv
module intr_seq_regs
  import intr_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          TRACE_BIT = 8,
  parameter int          IEN_BIT   = 9,
  parameter logic [DW-1:0] FLAGS_RST = 16'h0002,
  parameter logic [DW-1:0] CS_RST    = 16'hFFFF,
  parameter logic [DW-1:0] IP_RST    = 16'h0000,
  parameter logic [DW-1:0] SP_RST    = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          req_any,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_flags,
  input  logic [DW-1:0] ld_cs,
  input  logic [DW-1:0] ld_ip,
  input  logic [DW-1:0] ld_sp,
  output logic [DW-1:0] flags,
  output logic [DW-1:0] cs,
  output logic [DW-1:0] ip,
  output logic [DW-1:0] sp
);

  localparam logic [DW-1:0] WORD_STEP = DW'(2);
  localparam logic [DW-1:0] CLR_MASK  = ~((DW'(1) << TRACE_BIT) | (DW'(1) << IEN_BIT));

  logic [DW-1:0] flags_nxt, cs_nxt, ip_nxt, sp_nxt;
  logic          flags_en, cs_en, ip_en, sp_en;

  always_comb begin
    flags_nxt = flags;
    cs_nxt    = cs;
    ip_nxt    = ip;
    sp_nxt    = sp;
    flags_en  = 1'b0;
    cs_en     = 1'b0;
    ip_en     = 1'b0;
    sp_en     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ld_en && !req_any) begin
          flags_nxt = ld_flags;
          cs_nxt    = ld_cs;
          ip_nxt    = ld_ip;
          sp_nxt    = ld_sp;
          flags_en  = 1'b1;
          cs_en     = 1'b1;
          ip_en     = 1'b1;
          sp_en     = 1'b1;
        end
      end
      ST_PUSH_F: begin
        flags_nxt = flags & CLR_MASK;
        sp_nxt    = sp - WORD_STEP;
        flags_en  = mem_ready;
        sp_en     = mem_ready;
      end
      ST_PUSH_CS, ST_PUSH_IP: begin
        sp_nxt = sp - WORD_STEP;
        sp_en  = mem_ready;
      end
      ST_VEC_IP: begin
        ip_nxt = mem_rdata;
        ip_en  = mem_ready;
      end
      ST_VEC_CS: begin
        cs_nxt = mem_rdata;
        cs_en  = mem_ready;
      end
      ST_POP_IP: begin
        ip_nxt = mem_rdata;
        sp_nxt = sp + WORD_STEP;
        ip_en  = mem_ready;
        sp_en  = mem_ready;
      end
      ST_POP_CS: begin
        cs_nxt = mem_rdata;
        sp_nxt = sp + WORD_STEP;
        cs_en  = mem_ready;
        sp_en  = mem_ready;
      end
      ST_POP_F: begin
        flags_nxt = mem_rdata;
        sp_nxt    = sp + WORD_STEP;
        flags_en  = mem_ready;
        sp_en     = mem_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= FLAGS_RST;
    else if (flags_en) flags <= flags_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs <= CS_RST;
    else if (cs_en) cs <= cs_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip <= IP_RST;
    else if (ip_en) ip <= ip_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= SP_RST;
    else if (sp_en) sp <= sp_nxt;
  end

endmodule

// File: rtl/intr_seq_addr.sv
module intr_seq_addr
  import intr_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int SEG_SHIFT = 4,
  localparam int AW = DW + SEG_SHIFT
) (
  input  seq_state_e    state,
  input  logic [DW-1:0] ss,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] flags,
  input  logic [DW-1:0] cs,
  input  logic [DW-1:0] ip,
  input  logic [TW-1:0] vtype,
  output logic [AW-1:0] addr,
  output logic          rd,
  output logic          wr,
  output logic [DW-1:0] wdata
);

  localparam int VPAD = AW - TW - 2;

  logic [DW-1:0] offs;
  logic [AW-1:0] stk_addr;
  logic [AW-1:0] vec_addr;
  logic          use_vec;
  logic          hi_half;

  always_comb begin
    rd      = 1'b0;
    wr      = 1'b0;
    wdata   = '0;
    offs    = sp;
    use_vec = 1'b0;
    hi_half = 1'b0;
    case (state)
      ST_PUSH_F:  begin wr = 1'b1; wdata = flags; offs = sp - DW'(2); end
      ST_PUSH_CS: begin wr = 1'b1; wdata = cs;    offs = sp - DW'(2); end
      ST_PUSH_IP: begin wr = 1'b1; wdata = ip;    offs = sp - DW'(2); end
      ST_VEC_IP:  begin rd = 1'b1; use_vec = 1'b1; end
      ST_VEC_CS:  begin rd = 1'b1; use_vec = 1'b1; hi_half = 1'b1; end
      ST_POP_IP, ST_POP_CS, ST_POP_F: rd = 1'b1;
      default: ;
    endcase
  end

  assign stk_addr = {ss, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offs};
  assign vec_addr = {{VPAD{1'b0}}, vtype, hi_half, 1'b0};
  assign addr     = use_vec ? vec_addr : stk_addr;

endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_int,
  input  logic [7:0]  int_type,
  input  logic        req_iret,
  input  logic [15:0] stk_seg,
  input  logic        ld_en,
  input  logic [15:0] ld_flags,
  input  logic [15:0] ld_cs,
  input  logic [15:0] ld_ip,
  input  logic [15:0] ld_sp,
  output logic [19:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ready,
  output logic [15:0] ctx_flags,
  output logic [15:0] ctx_cs,
  output logic [15:0] ctx_ip,
  output logic [15:0] ctx_sp,
  output logic        busy,
  output logic        done
);

  localparam int DW = 16;
  localparam int TW = 8;

  seq_state_e    state;
  logic [TW-1:0] vtype;
  logic          req_any;

  assign req_any = req_int | req_iret;

  intr_seq_ctrl #(.TW(TW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_int   (req_int),
    .req_iret  (req_iret),
    .int_type  (int_type),
    .mem_ready (mem_ready),
    .state     (state),
    .vtype     (vtype),
    .busy      (busy),
    .done      (done)
  );

  intr_seq_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .req_any   (req_any),
    .ld_en     (ld_en),
    .ld_flags  (ld_flags),
    .ld_cs     (ld_cs),
    .ld_ip     (ld_ip),
    .ld_sp     (ld_sp),
    .flags     (ctx_flags),
    .cs        (ctx_cs),
    .ip        (ctx_ip),
    .sp        (ctx_sp)
  );

  intr_seq_addr #(.DW(DW), .TW(TW)) u_addr (
    .state (state),
    .ss    (stk_seg),
    .sp    (ctx_sp),
    .flags (ctx_flags),
    .cs    (ctx_cs),
    .ip    (ctx_ip),
    .vtype (vtype),
    .addr  (mem_addr),
    .rd    (mem_rd),
    .wr    (mem_wr),
    .wdata (mem_wdata)
  );

endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk
  import intr_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input seq_state_e  state,
  input logic [19:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [15:0] mem_wdata,
  input logic        mem_ready,
  input logic [15:0] ctx_flags,
  input logic [15:0] ctx_sp,
  input logic        busy,
  input logic        done
);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> busy);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr) && $stable(mem_wdata)));

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> (ctx_sp == $past(ctx_sp) - 16'd2));

  a_r5_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready && is_return(state)) |=> (ctx_sp == $past(ctx_sp) + 16'd2));

  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !is_return(state)) |-> (mem_addr < 20'h00400));

  a_r4_vec_sp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready && !is_return(state)) |=> $stable(ctx_sp));

  a_r3_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_F && mem_ready) |=>
      (ctx_flags[9:8] == 2'b00 && ctx_flags[15:10] == $past(ctx_flags[15:10])
       && ctx_flags[7:0] == $past(ctx_flags[7:0])));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind intr_seq intr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .ctx_flags (ctx_flags),
  .ctx_sp    (ctx_sp),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_intr_seq.sv
module test_intr_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_int, req_iret, ld_en;
  logic [7:0]  int_type;
  logic [15:0] stk_seg, ld_flags, ld_cs, ld_ip, ld_sp;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_ready = 1'b0;
  logic [15:0] ctx_flags, ctx_cs, ctx_ip, ctx_sp;
  logic        busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_seq i_intr_seq (
    .clk(clk), .rst_n(rst_n), .req_int(req_int), .int_type(int_type),
    .req_iret(req_iret), .stk_seg(stk_seg), .ld_en(ld_en),
    .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_sp(ld_sp),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ctx_flags(ctx_flags), .ctx_cs(ctx_cs), .ctx_ip(ctx_ip), .ctx_sp(ctx_sp),
    .busy(busy), .done(done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [15:0] mem [int];
  int          eq_addr [$];
  bit          eq_wr   [$];
  logic [15:0] eq_data [$];
  string       eq_tag  [$];

  logic [15:0] m_flags = 16'h0002, m_cs = 16'hFFFF, m_ip = 16'h0000, m_sp = 16'h0000;
  logic [15:0] p_flags, p_cs, p_ip, p_sp;
  bit          pend = 0;
  string       p_tag = "R1";
  int          lat = 0;
  int          wcnt = 0;
  bit          prev_done = 0;

  function automatic logic [15:0] mrd(int a);
    if (mem.exists(a)) return mem[a];
    return 16'hC000 ^ a[15:0];
  endfunction

  function automatic int phys(logic [15:0] s, logic [15:0] o);
    logic [19:0] r;
    r = {s, 4'h0} + {4'h0, o};
    return int'(r);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_acc(int a, bit w, logic [15:0] d, string tag);
    eq_addr.push_back(a);
    eq_wr.push_back(w);
    eq_data.push_back(d);
    eq_tag.push_back(tag);
  endtask

  task automatic build_int(logic [7:0] t, string tag);
    int vb;
    vb = int'(t) * 4;
    expect_acc(phys(stk_seg, m_sp - 16'd2), 1'b1, m_flags, "R2/R3");
    expect_acc(phys(stk_seg, m_sp - 16'd4), 1'b1, m_cs,    "R2");
    expect_acc(phys(stk_seg, m_sp - 16'd6), 1'b1, m_ip,    "R2");
    expect_acc(vb,     1'b0, 16'h0, "R4");
    expect_acc(vb + 2, 1'b0, 16'h0, "R4");
    p_ip    = mrd(vb);
    p_cs    = mrd(vb + 2);
    p_flags = m_flags & 16'hFCFF;
    p_sp    = m_sp - 16'd6;
    p_tag   = tag;
    pend    = 1;
  endtask

  task automatic build_ret(string tag);
    expect_acc(phys(stk_seg, m_sp),         1'b0, 16'h0, "R5");
    expect_acc(phys(stk_seg, m_sp + 16'd2), 1'b0, 16'h0, "R5");
    expect_acc(phys(stk_seg, m_sp + 16'd4), 1'b0, 16'h0, "R5");
    p_ip    = mrd(phys(stk_seg, m_sp));
    p_cs    = mrd(phys(stk_seg, m_sp + 16'd2));
    p_flags = mrd(phys(stk_seg, m_sp + 16'd4));
    p_sp    = m_sp + 16'd6;
    p_tag   = tag;
    pend    = 1;
  endtask

  // Reference memory, access order check and register comparison, each cycle
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    mem_ready = 1'b0;
    if (rst_n) begin
      if (mem_rd && mem_wr) check("R11", "both strobes", 1, 0);
      if ((mem_rd || mem_wr) && !busy) check("R11", "strobe while idle", 1, 0);
      if (mem_rd || mem_wr) begin
        if (eq_addr.size() == 0) begin
          check("R8", "unexpected access addr", {12'h0, mem_addr}, 32'hFFFFFFFF);
        end else begin
          check(eq_tag[0], "access addr", {12'h0, mem_addr}, eq_addr[0]);
          check(eq_tag[0], "access dir (R6 hold)", {31'h0, mem_wr}, {31'h0, eq_wr[0]});
          if (eq_wr[0]) check(eq_tag[0], "write data", {16'h0, mem_wdata}, {16'h0, eq_data[0]});
          if (wcnt == 0) begin
            mem_ready = 1'b1;
            if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata = mrd(int'(mem_addr));
            void'(eq_addr.pop_front());
            void'(eq_wr.pop_front());
            void'(eq_data.pop_front());
            void'(eq_tag.pop_front());
            wcnt = lat;
          end else begin
            wcnt--;
          end
        end
      end
      if (prev_done && done) check("R7", "done longer than one cycle", 1, 0);
      if (done) begin
        if (!pend) begin
          check("R7", "done without a sequence", 1, 0);
        end else begin
          check("R7", "accesses left at done", eq_addr.size(), 0);
          check("R7", "busy at done", {31'h0, busy}, 0);
          m_flags = p_flags; m_cs = p_cs; m_ip = p_ip; m_sp = p_sp;
          pend = 0;
        end
      end
      prev_done = done;
      if (!busy && !pend) begin
        check(p_tag, "flags", {16'h0, ctx_flags}, {16'h0, m_flags});
        check(p_tag, "cs",    {16'h0, ctx_cs},    {16'h0, m_cs});
        check(p_tag, "ip",    {16'h0, ctx_ip},    {16'h0, m_ip});
        check(p_tag, "sp",    {16'h0, ctx_sp},    {16'h0, m_sp});
      end
    end
  end

  task automatic do_load(logic [15:0] f, logic [15:0] c, logic [15:0] i, logic [15:0] s);
    @(negedge clk);
    ld_en = 1; ld_flags = f; ld_cs = c; ld_ip = i; ld_sp = s;
    m_flags = f; m_cs = c; m_ip = i; m_sp = s; p_tag = "R10";
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic send_int(logic [7:0] t, bit both, bit with_ld, string tag);
    @(negedge clk);
    build_int(t, tag);
    int_type = t; req_int = 1; req_iret = both;
    if (with_ld) begin
      ld_en = 1; ld_flags = 16'hDEAD; ld_cs = 16'hDEAD; ld_ip = 16'hDEAD; ld_sp = 16'hDEAD;
    end
    @(negedge clk);
    req_int = 0; req_iret = 0; ld_en = 0; int_type = 8'h77;
  endtask

  task automatic send_ret(string tag);
    @(negedge clk);
    build_ret(tag);
    req_iret = 1;
    @(negedge clk);
    req_iret = 0;
  endtask

  task automatic wait_done(string tag);
    for (int g = 0; g < 400 && pend; g++) @(negedge clk);
    if (pend) check(tag, "sequence never finished", 1, 0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog expired: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_int = 0; req_iret = 0; ld_en = 0; int_type = 0;
    stk_seg = 16'h2000; ld_flags = 0; ld_cs = 0; ld_ip = 0; ld_sp = 0;
    mem[32'hA0]  = 16'h8000; mem[32'hA2]  = 16'h1234;
    mem[32'h3FC] = 16'h4321; mem[32'h3FE] = 16'h0F0F;
    mem[32'h0]   = 16'h0101; mem[32'h2]   = 16'h0202;
    mem[32'hC]   = 16'h0C0C; mem[32'hE]   = 16'h0E0E;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "flags", ctx_flags, 16'h0002);
    check("R1", "cs",    ctx_cs,    16'hFFFF);
    check("R1", "ip",    ctx_ip,    16'h0000);
    check("R1", "sp",    ctx_sp,    16'h0000);
    check("R1", "strobes/busy/done", {mem_rd, mem_wr, busy, done}, 0);

    // R10 load, then R2/R3/R4 entry with zero wait
    do_load(16'h0F02, 16'h1234, 16'h0056, 16'h0100);
    lat = 0;
    send_int(8'h28, 0, 0, "R4");
    wait_done("R2");
    // R5 return with waits (R6)
    lat = 2;
    send_ret("R5");
    wait_done("R6");

    // top vector entry, plus R8 ignore of mid-sequence requests and loads
    lat = 1;
    send_int(8'hFF, 0, 0, "R4");
    @(negedge clk);
    req_int = 1; req_iret = 1; int_type = 8'h07;
    ld_en = 1; ld_flags = 16'h1111; ld_cs = 16'h2222; ld_ip = 16'h3333; ld_sp = 16'h4444;
    @(negedge clk);
    req_int = 0; req_iret = 0; ld_en = 0;
    wait_done("R8");
    send_ret("R5");
    wait_done("R5");

    // R8 both requests together: entry wins; R10 load dropped with a request
    lat = 0;
    send_int(8'h00, 1, 1, "R8");
    wait_done("R8");
    send_ret("R10");
    wait_done("R10");

    // R9 wrap of SP and physical address
    stk_seg = 16'hFFFF;
    do_load(16'h0302, 16'hABCD, 16'h0010, 16'h0004);
    lat = 1;
    send_int(8'h03, 0, 0, "R9");
    wait_done("R9");
    send_ret("R9");
    wait_done("R9");

    repeat (5) @(negedge clk);
    check("R11", "stray expected accesses", eq_addr.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule